// File: doc/BRIEF.md
# Ring-Oscillator Frequency Monitor

This block measures how fast an on-die ring oscillator runs, as a proxy for the local process corner and supply voltage. Several free-running oscillator outputs enter as plain toggling wires. Software picks one of them and programs a measurement window as a number of reference-clock cycles. With a 24 MHz reference, a window of N microseconds is N×24 cycles. After a start command the block counts rising edges of the chosen oscillator for that window, stores the count and raises a completion flag.

Oscillator edges are brought into the reference domain through a two-stage synchroniser followed by an edge detector, so an oscillator must run below half the reference frequency to be counted one-to-one. Software reaches the block through a simple register port. A word written to the control register carries a per-bit write-enable mask in its upper half, so single fields change without a read-modify-write. A single-ring build ignores the ring-select field.

Top module: `pvtm_freq_mon`

## Requirements
- R1: After reset, the control word (0x04), the window register (0x08), the status word (0x80) and the result register (0x84) all read 0.
- R2: A write to 0x04 changes bit i of the control word (i in 0..15) only when write-data bit 16+i is 1. The other bits keep their value. Bit 0 is start, bit 1 is enable and bits 4:2 are the ring index. Writes to 0x04 read back through the same bit positions.
- R3: A write to 0x08 loads the whole 32-bit window length, and it reads back unchanged.
- R4: A rising edge of start while enable is 1 launches a measurement and clears done and the result. With window N, status bit 0 (done) reads 0 until N+2 clock edges after the edge that wrote start, and reads 1 from that edge on.
- R5: A window of 0 sets done two edges after the start write, with a result of 0.
- R6: The result register holds the number of rising edges of the selected oscillator seen during the window, within ±2 of N divided by the oscillator period in reference cycles.
- R7: A ring index at or above the number of rings gives a count of 0. A single-ring build counts its only ring whatever the index.
- R8: The count saturates at 2^CNT_W−1 and never wraps.
- R9: Clearing start or enable stops a measurement and clears done on the following edge. A measurement stopped before expiry leaves the result at 0. A stop that lands on the expiry edge keeps the latched count.
- R10: Writes to 0x80 and 0x84 change neither done nor the result.
- R11: After done, the result stays constant until the next launch, including after start is cleared.
- R12: Setting start while enable is 0 launches nothing. Setting enable while start is already 1 also launches nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that times the window |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data; bits 31:16 are the control write mask |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ring_osc | input | NUM_RINGS | Oscillator outputs, asynchronous to clk |

## Verification
Window expiry and a software stop can land on the same clock edge. The expiry latches the count and raises done, while the stop drops start. The bench times a control write that clears start so that it lands exactly on the expiry edge, N+2 edges after the start write. It then checks that done reads 1 for that one cycle and 0 on the next, and that the result keeps a count near the expected edge number instead of 0.

// File: rtl/pvtm_pkg.sv
// Shared register offsets, control bit positions and field widths for the
// ring-oscillator frequency monitor. Assumes an 8-bit byte-offset register bus.
package pvtm_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_WIN    = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h80;
    localparam logic [7:0] OFS_RESULT = 8'h84;

    localparam int CTL_W      = 16;   // writable half of the control word
    localparam int MASK_LO    = 16;   // first write-mask bit
    localparam int BIT_START  = 0;
    localparam int BIT_ENABLE = 1;
    localparam int SEL_LO     = 2;
    localparam int SEL_W      = 3;
endpackage

// File: rtl/pvtm_ctrl_regs.sv
// Control word with per-bit write masking, and the window-length register.
// Assumes a single-cycle write strobe; reads are handled by the top level.
module pvtm_ctrl_regs
    import pvtm_pkg::*;
#(
    parameter int WIN_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [CTL_W-1:0]     ctl_word,
    output logic [WIN_W-1:0]     win_len
);
    logic             wr_ctl;
    logic             wr_win;
    logic [CTL_W-1:0] ctl_mask;
    logic [CTL_W-1:0] ctl_next;

    // Decode the target register and merge masked bits into the control word.
    always_comb begin
        wr_ctl   = bus_wr && (bus_addr == OFS_CTRL);
        wr_win   = bus_wr && (bus_addr == OFS_WIN);
        ctl_mask = bus_wdata[MASK_LO +: CTL_W];
        ctl_next = (ctl_word & ~ctl_mask) | (bus_wdata[CTL_W-1:0] & ctl_mask);
    end

    // Hold the control word; only masked bits follow a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_word <= '0;
        else if (wr_ctl) ctl_word <= ctl_next;
    end

    // Hold the window length in reference cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_len <= '0;
        else if (wr_win) win_len <= bus_wdata[WIN_W-1:0];
    end

    // R2: an unmasked start bit survives a control write.
    p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[MASK_LO + BIT_START]) |=>
            (ctl_word[BIT_START] == $past(ctl_word[BIT_START])));

    // R3: a window write is visible on the next cycle.
    p_window_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win |=> (win_len == $past(bus_wdata[WIN_W-1:0])));
endmodule

// File: rtl/pvtm_ring_sync.sv
// Brings every oscillator into the clk domain through a synchroniser chain,
// selects one and emits a one-cycle pulse per rising edge. Assumes each
// oscillator phase lasts at least one clk period. An index beyond the last
// ring selects nothing; a single-ring build ignores the index.
module pvtm_ring_sync
    import pvtm_pkg::*;
#(
    parameter int NUM_RINGS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RINGS-1:0] ring_osc,
    input  logic [SEL_W-1:0]     ring_sel,
    output logic                 edge_pulse
);
    logic [NUM_RINGS-1:0] stage [SYNC_STAGES];
    logic [NUM_RINGS-1:0] synced;
    logic                 chosen;
    logic                 chosen_q;

    // Shift every oscillator through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= ring_osc;
            for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign synced = stage[SYNC_STAGES-1];

    generate
        if (NUM_RINGS == 1) begin : g_single
            // Only one oscillator exists: the index has no effect.
            always_comb chosen = synced[0];
        end else begin : g_multi
            // Pick the indexed oscillator; unmatched indexes give 0.
            always_comb begin
                chosen = 1'b0;
                for (int i = 0; i < NUM_RINGS; i++)
                    if (ring_sel == SEL_W'(i)) chosen = synced[i];
            end
        end
    endgenerate

    // Remember the previous selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chosen_q <= 1'b0;
        else        chosen_q <= chosen;
    end

    assign edge_pulse = chosen & ~chosen_q;

    // R6: an edge pulse never lasts two cycles.
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/pvtm_window_ctr.sv
// Window timer and saturating edge counter. Launches on a rising start while
// enable is high, counts edge pulses until the timer runs out, then latches
// the count and raises done. Dropping start or enable stops it.
module pvtm_window_ctr #(
    parameter int WIN_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             enable,
    input  logic [WIN_W-1:0] win_len,
    input  logic             edge_pulse,
    output logic             done,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             start_q;
    logic             launch;
    logic             go;
    logic             active_q;
    logic             expire;
    logic [WIN_W-1:0] timer_q;
    logic [CNT_W-1:0] cnt_q;

    // Remember start to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    // Derive launch, run and expiry conditions.
    always_comb begin
        go     = start & enable;
        launch = start & ~start_q & enable;
        expire = active_q & go & (timer_q == '0);
    end

    // Sequence the measurement: launch, count down, expire or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            timer_q  <= '0;
            done     <= 1'b0;
        end else if (launch) begin
            active_q <= 1'b1;
            timer_q  <= win_len;
            done     <= 1'b0;
        end else if (!go) begin
            active_q <= 1'b0;
            done     <= 1'b0;
        end else if (expire) begin
            active_q <= 1'b0;
            done     <= 1'b1;
        end else if (active_q) begin
            timer_q  <= timer_q - 1'b1;
        end
    end

    // Count edges during the window, holding at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || launch)
            cnt_q <= '0;
        else if (active_q && go && !expire && edge_pulse && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    // Latch the count at expiry; clear it when a new launch begins.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) result <= '0;
        else if (expire)      result <= cnt_q;
    end

    // R4: a launch always leaves done low.
    p_launch_clears_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !done);

    // R4: done only rises out of an active window.
    p_done_from_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(active_q));

    // R9: losing start or enable drops done.
    p_abort_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !done);

    // R8: a full counter stays full.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && go && !launch && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R11: the result moves only on launch or expiry.
    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !expire) |=> $stable(result));
endmodule

// File: rtl/pvtm_freq_mon.sv
// Top level of the ring-oscillator frequency monitor: registers, oscillator
// synchronisation, window counting and the read mux. Assumes CNT_W and
// WIN_W do not exceed 32 and that clk is the reference clock.
module pvtm_freq_mon
    import pvtm_pkg::*;
#(
    parameter int NUM_RINGS   = 4,
    parameter int WIN_W       = 32,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_RINGS-1:0] ring_osc
);
    logic [CTL_W-1:0] ctl_word;
    logic [WIN_W-1:0] win_len;
    logic             edge_pulse;
    logic             done;
    logic [CNT_W-1:0] result;

    pvtm_ctrl_regs #(.WIN_W(WIN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctl_word  (ctl_word),
        .win_len   (win_len)
    );

    pvtm_ring_sync #(.NUM_RINGS(NUM_RINGS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_osc   (ring_osc),
        .ring_sel   (ctl_word[SEL_LO +: SEL_W]),
        .edge_pulse (edge_pulse)
    );

    pvtm_window_ctr #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ctl_word[BIT_START]),
        .enable     (ctl_word[BIT_ENABLE]),
        .win_len    (win_len),
        .edge_pulse (edge_pulse),
        .done       (done),
        .result     (result)
    );

    // Return the register addressed by bus_addr; unknown offsets read 0.
    always_comb begin
        case (bus_addr)
            OFS_CTRL:   bus_rdata = 32'(ctl_word);
            OFS_WIN:    bus_rdata = 32'(win_len);
            OFS_STAT:   bus_rdata = {31'b0, done};
            OFS_RESULT: bus_rdata = 32'(result);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_pvtm_freq_mon.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_pvtm_freq_mon;
    localparam logic [7:0] A_CTRL = 8'h04, A_WIN = 8'h08, A_STAT = 8'h80, A_RES = 8'h84;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [3:0]  ring = '0;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    // Oscillators with periods of 6, 10, 4 and 16 reference cycles.
    initial begin #3; forever #24 ring[0] = ~ring[0]; end
    initial begin #3; forever #40 ring[1] = ~ring[1]; end
    initial begin #3; forever #16 ring[2] = ~ring[2]; end
    initial begin #3; forever #64 ring[3] = ~ring[3]; end

    pvtm_freq_mon #(.NUM_RINGS(4), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .ring_osc(ring));

    pvtm_freq_mon #(.NUM_RINGS(1), .CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .ring_osc(ring[1:1]));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input logic [31:0] act, input int exp, input int tol);
        checks++;
        if (int'(act) < exp - tol || int'(act) > exp + tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d +/- %0d", tag, act, exp, tol);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v0, output logic [31:0] v1);
        @(negedge clk);
        bus_addr = a;
        #1 v0 = rdata0; v1 = rdata1;
    endtask

    // Configure a ring and window, launch, poll done, return both results.
    task automatic measure(input logic [2:0] sel, input int win,
                           output logic [31:0] r0, output logic [31:0] r1);
        logic [31:0] dummy;
        wr(A_CTRL, 32'h0001_0000);
        wr(A_CTRL, 32'h001E_0000 | (32'(sel) << 2) | 32'h2);
        wr(A_WIN, 32'(win));
        wr(A_CTRL, 32'h0001_0001);
        bus_addr = A_STAT;
        for (int i = 0; i < win + 20; i++) begin
            @(posedge clk); #2;
            if (rdata0[0]) break;
        end
        check("R4 done reached", rdata0 & 32'h1, 32'h1);
        rd(A_RES, r0, r1);
        dummy = r0;
    endtask

    task automatic t_reset;
        logic [31:0] v0, v1;
        rd(A_CTRL, v0, v1); check("R1 ctrl", v0, 0);
        rd(A_WIN, v0, v1);  check("R1 window", v0, 0);
        rd(A_STAT, v0, v1); check("R1 status", v0, 0);
        rd(A_RES, v0, v1);  check("R1 result", v0, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v0, v1;
        wr(A_CTRL, 32'h001C_0014);
        rd(A_CTRL, v0, v1); check("R2 masked ring field", v0, 32'h14);
        wr(A_CTRL, 32'h0002_FFFF);
        rd(A_CTRL, v0, v1); check("R2 enable only", v0, 32'h16);
        wr(A_CTRL, 32'h0000_FFFF);
        rd(A_CTRL, v0, v1); check("R2 empty mask", v0, 32'h16);
        wr(A_WIN, 32'hA5A5_1234);
        rd(A_WIN, v0, v1);  check("R3 window readback", v0, 32'hA5A5_1234);
        wr(A_CTRL, 32'hFFFF_0000);
    endtask

    task automatic t_timing;
        logic [31:0] v0, v1;
        int n = 37;
        wr(A_CTRL, 32'h001F_0002);
        wr(A_WIN, 32'(n));
        wr(A_CTRL, 32'h0001_0001);
        bus_addr = A_STAT;
        repeat (n + 1) @(posedge clk);
        #2 check("R4 done low at N+1", rdata0 & 32'h1, 0);
        @(posedge clk);
        #2 check("R4 done high at N+2", rdata0 & 32'h1, 1);
        rd(A_RES, v0, v1); check_near("R6 ring0 window37", v0, 6, 2);
    endtask

    task automatic t_counts;
        logic [31:0] r0, r1;
        measure(3'd0, 120, r0, r1); check_near("R6 ring0", r0, 20, 2);
        measure(3'd1, 300, r0, r1); check_near("R6 ring1", r0, 30, 2);
        measure(3'd3, 160, r0, r1); check_near("R7 ring3 select", r0, 10, 2);
        measure(3'd6, 300, r0, r1);
        check("R7 out-of-range ring", r0, 0);
        check_near("R7 single ring ignores index", r1, 30, 2);
        measure(3'd2, 1200, r0, r1); check("R8 saturation", r0, 255);
    endtask

    task automatic t_hold_and_ro;
        logic [31:0] r0, r1, v0, v1;
        measure(3'd0, 90, r0, r1);
        repeat (30) @(posedge clk);
        rd(A_RES, v0, v1); check("R11 result holds", v0, r0);
        wr(A_STAT, 32'h0);
        wr(A_RES, 32'hFFFF_FFFF);
        rd(A_STAT, v0, v1); check("R10 status write ignored", v0, 1);
        rd(A_RES, v0, v1);  check("R10 result write ignored", v0, r0);
        wr(A_CTRL, 32'h0001_0000);
        rd(A_RES, v0, v1);  check("R11 result after start clear", v0, r0);
        rd(A_STAT, v0, v1); check("R9 done cleared by stop", v0, 0);
    endtask

    task automatic t_abort;
        logic [31:0] v0, v1;
        wr(A_CTRL, 32'h001F_0002);
        wr(A_WIN, 32'd200);
        wr(A_CTRL, 32'h0001_0001);
        repeat (50) @(posedge clk);
        wr(A_CTRL, 32'h0002_0000);
        repeat (300) @(posedge clk);
        rd(A_STAT, v0, v1); check("R9 aborted done", v0, 0);
        rd(A_RES, v0, v1);  check("R9 aborted result", v0, 0);
    endtask

    // Stop lands on the same edge as window expiry.
    task automatic t_collision;
        logic [31:0] v0, v1;
        int n = 60;
        wr(A_CTRL, 32'h001F_0002);
        wr(A_WIN, 32'(n));
        wr(A_CTRL, 32'h0001_0001);
        repeat (n + 1) @(posedge clk);
        wr(A_CTRL, 32'h0001_0000);
        rd(A_STAT, v0, v1); check("R9 done on expiry edge", v0, 1);
        rd(A_STAT, v0, v1); check("R9 done cleared after stop", v0, 0);
        rd(A_RES, v0, v1);  check_near("R9 count kept at collision", v0, 10, 2);
    endtask

    task automatic t_enable_gate;
        logic [31:0] v0, v1;
        wr(A_CTRL, 32'hFFFF_0000);
        wr(A_WIN, 32'd0);
        wr(A_CTRL, 32'h0003_0001);
        repeat (20) @(posedge clk);
        rd(A_STAT, v0, v1); check("R12 start without enable", v0, 0);
        wr(A_CTRL, 32'h0002_0002);
        repeat (10) @(posedge clk);
        rd(A_STAT, v0, v1); check("R12 enable under held start", v0, 0);
        wr(A_CTRL, 32'h0001_0000);
        wr(A_CTRL, 32'h0001_0001);
        bus_addr = A_STAT;
        @(posedge clk);
        #2 check("R5 zero window not yet done", rdata0 & 32'h1, 0);
        @(posedge clk);
        #2 check("R5 zero window done", rdata0 & 32'h1, 1);
        rd(A_RES, v0, v1); check("R5 zero window result", v0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_timing();
        t_counts();
        t_hold_and_ro();
        t_abort();
        t_collision();
        t_enable_gate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule